// File: doc/BRIEF.md
# EDO DRAM Device Control Model

This block models the control logic that sits inside a multiplexed-address DRAM with extended-data-out page access. A system clock samples the four active-low strobes (row strobe, column strobe, write enable, output enable) and a shared address bus. The row address is taken when the row strobe falls and the column address when the column strobe falls. The block then reads from or writes to a small internal word array. Read data stays on the output after the column strobe rises and is only released by an explicit condition, so a controller can overlap the next column cycle with sampling the previous word.

Each row-strobe cycle is one of four kinds, chosen by the order of the strobe edges: a normal access with any number of page-mode column cycles, an early write, a read-modify-write, or a refresh. A refresh is either column-before-row, which takes its row from an internal counter, or row-only, which takes the row from the address pins. If the row and column strobes are both held low long enough, the block enters self refresh and walks the counter on its own. Refresh activity appears as a one-cycle pulse with the refreshed row, standing in for the cell restore that a real array would do. The bidirectional data pins are split into `din`, `dout` and `dout_en`. The array geometry is set by parameters; the full-size part would use 12 row and 11 column bits.

Top module: `edo_dram_core`

## Requirements
- R1: After reset, `dout_en`, `refresh_pulse` and `self_refresh` are 0 and the refresh counter is at row 0.
- R2: The row is latched from `addr[ROW_W-1:0]` when `ras_n` falls with `cas_n` high, and the column from `addr[COL_W-1:0]` when `cas_n` falls. With `we_n` high and `oe_n` low, `dout` then shows the word stored at that row and column, and `dout_en` is 1.
- R3: If `we_n` is low when `cas_n` falls (early write), `din` is stored at the addressed word and `dout_en` stays 0.
- R4: While `ras_n` stays low, each further `cas_n` fall with a new column reads or writes that column in the row already latched (page mode).
- R5: After a read, `dout` and `dout_en` = 1 are held when `cas_n` rises with `ras_n` still low. The output is released (`dout_en` = 0) once `ras_n` and `cas_n` are both high.
- R6: While `oe_n` is high, `dout_en` is 0. If the read data has not been released, it is driven again when `oe_n` returns low.
- R7: A `we_n` fall after a read, with `cas_n` still low, writes `din` to the word just read (read-modify-write) and sets `dout_en` to 0.
- R8: A `ras_n` fall while `cas_n` is already low gives one `refresh_pulse` whose `refresh_row` is the counter value. The counter then steps by one, modulo 2^ROW_W. The address pins are ignored and the array is left unchanged.
- R9: Raising and lowering `ras_n` again while `cas_n` stays low after a read (hidden refresh) performs an R8 refresh. Throughout that refresh, `dout_en` = 1 and the earlier read word stay on the output.
- R10: A `ras_n` low period with no `cas_n` fall (row-only refresh) gives one `refresh_pulse` with `refresh_row` equal to the latched row. The refresh counter is not changed.
- R11: If `ras_n` and `cas_n` are both held low for SELF_ENTRY cycles after a column-before-row entry, `self_refresh` goes to 1. A `refresh_pulse` with the next counter row then follows every SELF_PERIOD cycles. `self_refresh` returns to 0 after `ras_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Shared row/column address bus |
| din | input | DATA_W | Write data (input half of the data pins) |
| dout | output | DATA_W | Read data (output half of the data pins) |
| dout_en | output | 1 | Output driver enable; 0 means high impedance |
| refresh_pulse | output | 1 | One-cycle pulse per refreshed row |
| refresh_row | output | ROW_W | Row refreshed by the current pulse |
| self_refresh | output | 1 | High while the block is in self refresh |

## Verification
The hidden refresh is the case where two functions coincide. A column-before-row refresh runs while the extended output still drives the word from the previous read, so the counter advance and the held output fall on the same row-strobe edge. The bench provokes it by reading a word, keeping `cas_n` low and pulsing `ras_n`. It then judges the result from one refresh pulse carrying the predicted counter row while `dout` and `dout_en` stay unchanged. A second overlap is the read-modify-write: a write goes into a location whose data is still being driven. It is judged by the output turning off and by a later read returning the new word.

// File: rtl/edo_pkg.sv
// Package: shared types for the EDO DRAM control model.
// Assumes nothing beyond IEEE 1800-2017.
package edo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // row strobe high, no cycle in progress
        ST_ROW  = 2'd1,  // row latched, access or row-only refresh
        ST_CBR  = 2'd2,  // column-before-row refresh cycle
        ST_SELF = 2'd3   // self refresh running
    } edo_state_e;
endpackage

// File: rtl/edo_sync.sv
// Module: two-stage synchroniser for a vector of asynchronous inputs.
// Assumes the bits of a vector are only consumed after they have been stable
// for several clocks (the strobe protocol guarantees this for address/data).
module edo_sync #(
    parameter int W       = 1,
    parameter bit RST_ONE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two flops in series, reset to the idle level of the inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= {W{RST_ONE}};
            q      <= {W{RST_ONE}};
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/edo_refresh_ctr.sv
// Module: internal refresh row counter, wraps modulo 2^ROW_W.
// Assumes adv is a single-cycle request per refreshed row.
module edo_refresh_ctr #(
    parameter int ROW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    // Step the counter once per request.
    always_ff @(posedge clk) begin
        if (!rst_n) row <= '0;
        else if (adv) row <= row + 1'b1;
    end

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (row != $past(row)) |-> (row == ROW_W'($past(row) + 1'b1))); // R8
endmodule

// File: rtl/edo_array.sv
// Module: word array with one synchronous write port and one combinational read port.
// Assumes depth 2^(ROW_W+COL_W) stays small; contents are not reset.
module edo_array #(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic [ROW_W+COL_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [ROW_W+COL_W-1:0] rd_idx,
    output logic [DATA_W-1:0]      rd_data
);
    localparam int DEPTH = 1 << (ROW_W + COL_W);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word per write request.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // Read the addressed word without delay.
    always_comb rd_data = mem[rd_idx];
endmodule

// File: rtl/edo_dram_core.sv
// Module: device-side control of a multiplexed-address EDO DRAM.
// Assumes strobes are asynchronous and change slowly compared with clk;
// address and din are stable around each strobe edge. Each edge acts three
// clocks after the pin change (two sync stages plus the edge flop).
module edo_dram_core
    import edo_pkg::*;
#(
    parameter int ROW_W       = 3,
    parameter int COL_W       = 3,
    parameter int DATA_W      = 8,
    parameter int SELF_ENTRY  = 40,
    parameter int SELF_PERIOD = 8,
    localparam int ADDR_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              refresh_pulse,
    output logic [ROW_W-1:0]  refresh_row,
    output logic              self_refresh
);
    localparam int IDX_W  = ROW_W + COL_W;
    localparam int CMAX   = (SELF_ENTRY > SELF_PERIOD) ? SELF_ENTRY : SELF_PERIOD;
    localparam int CNT_W  = $clog2(CMAX) + 1;

    logic [3:0]              stb_s;
    logic                    s_ras, s_cas, s_we, s_oe;
    logic [2:0]              prev_q;
    logic                    ras_fall, ras_rise, cas_fall, we_fall;
    logic [ADDR_W-1:0]       addr_s;
    logic [DATA_W-1:0]       din_s;
    logic [COL_W-1:0]        col_in;
    edo_state_e              state;
    logic [ROW_W-1:0]        row_q;
    logic [COL_W-1:0]        col_q;
    logic                    cas_seen, rd_done, drive_q, drive_d;
    logic [CNT_W-1:0]        cnt_q;
    logic                    self_tick, ctr_adv, row_only, rd_now;
    logic                    wr_en;
    logic [IDX_W-1:0]        wr_idx;
    logic [DATA_W-1:0]       rd_data;
    logic [ROW_W-1:0]        ctr_row;

    edo_sync #(.W(4), .RST_ONE(1'b1)) i_stb_sync (
        .clk(clk), .rst_n(rst_n), .d({oe_n, we_n, cas_n, ras_n}), .q(stb_s));

    edo_sync #(.W(ADDR_W + DATA_W), .RST_ONE(1'b0)) i_dat_sync (
        .clk(clk), .rst_n(rst_n), .d({addr, din}), .q({addr_s, din_s}));

    assign s_ras  = stb_s[0];
    assign s_cas  = stb_s[1];
    assign s_we   = stb_s[2];
    assign s_oe   = stb_s[3];
    assign col_in = addr_s[COL_W-1:0];

    // Remember the previous synchronised strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 3'b111;
        else        prev_q <= stb_s[2:0];
    end

    assign ras_fall = prev_q[0] & ~s_ras;
    assign ras_rise = ~prev_q[0] & s_ras;
    assign cas_fall = prev_q[1] & ~s_cas;
    assign we_fall  = prev_q[2] & ~s_we;

    // Decode the per-cycle actions of the current state.
    always_comb begin
        rd_now    = (state == ST_ROW) && cas_fall && s_we;
        self_tick = (state == ST_SELF) && !ras_rise && (cnt_q == CNT_W'(SELF_PERIOD - 1));
        ctr_adv   = ((state == ST_IDLE) && ras_fall && !s_cas) || self_tick;
        row_only  = (state == ST_ROW) && ras_rise && !cas_seen;
    end

    // Choose the write source: early write first, then read-modify-write.
    always_comb begin
        wr_en  = 1'b0;
        wr_idx = {row_q, col_in};
        if ((state == ST_ROW) && cas_fall && !s_we) begin
            wr_en = 1'b1;
        end else if ((state == ST_ROW) && we_fall && !s_cas && rd_done) begin
            wr_en  = 1'b1;
            wr_idx = {row_q, col_q};
        end
    end

    // Output driver state: set by a read, cleared by write, WE# pulse or both strobes high.
    always_comb begin
        drive_d = drive_q;
        if ((state == ST_ROW) && cas_fall) drive_d = s_we;
        if (we_fall)                       drive_d = 1'b0;
        if (s_ras && s_cas)                drive_d = 1'b0;
    end

    // Cycle sequencing, data capture and refresh reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            row_q         <= '0;
            col_q         <= '0;
            cas_seen      <= 1'b0;
            rd_done       <= 1'b0;
            drive_q       <= 1'b0;
            dout_en       <= 1'b0;
            dout          <= '0;
            cnt_q         <= '0;
            refresh_pulse <= 1'b0;
            refresh_row   <= '0;
        end else begin
            drive_q       <= drive_d;
            dout_en       <= drive_d & ~s_oe;
            refresh_pulse <= ctr_adv | row_only;
            if (ctr_adv)       refresh_row <= ctr_row;
            else if (row_only) refresh_row <= row_q;
            if (rd_now) dout <= rd_data;
            case (state)
                ST_IDLE: begin
                    if (ras_fall) begin
                        if (!s_cas) begin
                            state <= ST_CBR;
                            cnt_q <= '0;
                        end else begin
                            state    <= ST_ROW;
                            row_q    <= addr_s[ROW_W-1:0];
                            cas_seen <= 1'b0;
                            rd_done  <= 1'b0;
                        end
                    end
                end
                ST_ROW: begin
                    if (ras_rise) begin
                        state <= ST_IDLE;
                    end else if (cas_fall) begin
                        col_q    <= col_in;
                        cas_seen <= 1'b1;
                        rd_done  <= s_we;
                    end
                end
                ST_CBR: begin
                    if (ras_rise) begin
                        state <= ST_IDLE;
                    end else if (!s_cas) begin
                        if (cnt_q == CNT_W'(SELF_ENTRY - 1)) begin
                            state <= ST_SELF;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_SELF: begin
                    if (ras_rise)       state <= ST_IDLE;
                    else if (self_tick) cnt_q <= '0;
                    else                cnt_q <= cnt_q + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign self_refresh = (state == ST_SELF);

    edo_refresh_ctr #(.ROW_W(ROW_W)) i_ref_ctr (
        .clk(clk), .rst_n(rst_n), .adv(ctr_adv), .row(ctr_row));

    edo_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) i_array (
        .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(din_s),
        .rd_idx({row_q, col_in}), .rd_data(rd_data));

    AST_RELEASE_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ras && s_cas) |=> !dout_en); // R5
    AST_OE_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        s_oe |=> !dout_en); // R6
    AST_EARLY_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ROW) && cas_fall && !s_we) |=> !dout_en); // R3
    AST_RMW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ROW) && we_fall) |=> !dout_en); // R7
    AST_SELF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        s_ras |=> !self_refresh); // R11
endmodule

// File: tb/test_edo_dram_core.sv
// Bench: near-exhaustive sweep of the 8x8 default array plus strobe-order cases.
module test_edo_dram_core;
    localparam int ROW_W = 3, COL_W = 3, DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int ST = 6;   // clocks allowed for each strobe change to take effect

    logic clk = 1'b0, rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic dout_en, refresh_pulse, self_refresh;
    logic [ROW_W-1:0] refresh_row;

    int checks = 0, errors = 0;
    int n_ref = 0;
    logic [ROW_W-1:0] last_ref = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    edo_dram_core i_edo_dram_core (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .refresh_pulse(refresh_pulse), .refresh_row(refresh_row),
        .self_refresh(self_refresh));

    // Count refresh pulses seen at the ports.
    always @(posedge clk) begin
        if (rst_n && refresh_pulse) begin
            n_ref    <= n_ref + 1;
            last_ref <= refresh_row;
        end
    end

    function automatic logic [7:0] pat(input int r, input int c);
        return 8'((r * 16 + c) ^ 8'h5A);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic row_open(input int r);
        addr = ADDR_W'(r); ras_n = 1'b0; tick(ST);
    endtask

    task automatic row_close();
        ras_n = 1'b1; tick(ST);
    endtask

    task automatic col_write(input int c, input logic [7:0] d, input bit look);
        addr = ADDR_W'(c); din = d; we_n = 1'b0; cas_n = 1'b0; tick(ST);
        if (look) chk("R3 dout_en during early write", int'(dout_en), 0);
        cas_n = 1'b1; we_n = 1'b1; tick(ST);
    endtask

    task automatic col_read(input int r, input int c, input string req);
        addr = ADDR_W'(c); we_n = 1'b1; cas_n = 1'b0; tick(ST);
        chk(req, int'(dout_en), 1);
        chk(req, int'(dout), int'(pat(r, c)));
        cas_n = 1'b1; tick(ST);
    endtask

    initial begin
        int base, n0;
        tick(4);
        chk("R1 dout_en at reset", int'(dout_en), 0);
        chk("R1 refresh_pulse at reset", int'(refresh_pulse), 0);
        chk("R1 self_refresh at reset", int'(self_refresh), 0);
        rst_n = 1'b1; tick(4);

        // R3 / R4: fill the array by early writes in page mode
        for (int r = 0; r < 8; r++) begin
            row_open(r);
            for (int c = 0; c < 8; c++) col_write(c, pat(r, c), c == 0);
            row_close();
        end
        // R2 / R4: read back every word, one page per row
        for (int r = 0; r < 8; r++) begin
            row_open(r);
            for (int c = 0; c < 8; c++) col_read(r, c, "R2 R4 page read");
            row_close();
        end

        // R5 / R6: extended output hold and release
        row_open(5);
        addr = 3'd2; cas_n = 1'b0; tick(ST);
        cas_n = 1'b1; tick(ST);
        chk("R5 held dout_en after CAS high", int'(dout_en), 1);
        chk("R5 held dout after CAS high", int'(dout), int'(pat(5, 2)));
        oe_n = 1'b1; tick(ST);
        chk("R6 dout_en with OE high", int'(dout_en), 0);
        oe_n = 1'b0; tick(ST);
        chk("R6 dout_en after OE low again", int'(dout_en), 1);
        row_close();
        chk("R5 release with both strobes high", int'(dout_en), 0);

        // R7: read-modify-write
        row_open(1);
        addr = 3'd3; cas_n = 1'b0; tick(ST);
        chk("R7 read before modify", int'(dout), int'(pat(1, 3)));
        din = 8'h3C; we_n = 1'b0; tick(ST);
        chk("R7 dout_en after WE fall", int'(dout_en), 0);
        we_n = 1'b1; cas_n = 1'b1; tick(ST);
        row_close();
        row_open(1);
        addr = 3'd3; cas_n = 1'b0; tick(ST);
        chk("R7 modified word", int'(dout), 8'h3C);
        cas_n = 1'b1; tick(ST);
        row_close();

        // R8: two CBR refreshes, address ignored
        for (int k = 0; k < 2; k++) begin
            n0 = n_ref;
            cas_n = 1'b0; addr = 3'd7; tick(ST);
            ras_n = 1'b0; tick(ST);
            ras_n = 1'b1; tick(ST);
            cas_n = 1'b1; tick(ST);
            chk("R8 one pulse per CBR", n_ref - n0, 1);
            chk("R8 counter row", int'(last_ref), k);
        end
        row_open(7);
        col_read(7, 7, "R8 array unchanged by CBR");
        row_close();

        // R9: hidden refresh keeps the read data
        row_open(2);
        addr = 3'd4; cas_n = 1'b0; tick(ST);
        n0 = n_ref;
        ras_n = 1'b1; tick(ST);
        ras_n = 1'b0; tick(ST);
        chk("R9 pulse count", n_ref - n0, 1);
        chk("R9 refreshed row", int'(last_ref), 2);
        chk("R9 dout_en held", int'(dout_en), 1);
        chk("R9 dout held", int'(dout), int'(pat(2, 4)));
        ras_n = 1'b1; tick(ST);
        cas_n = 1'b1; tick(ST);
        chk("R5 release after hidden refresh", int'(dout_en), 0);

        // R10: row-only refresh
        n0 = n_ref;
        row_open(6);
        row_close();
        chk("R10 pulse count", n_ref - n0, 1);
        chk("R10 latched row", int'(last_ref), 6);
        chk("R10 no output", int'(dout_en), 0);
        cas_n = 1'b0; tick(ST); ras_n = 1'b0; tick(ST);
        ras_n = 1'b1; tick(ST); cas_n = 1'b1; tick(ST);
        chk("R10 counter untouched", int'(last_ref), 3);

        // R11: self refresh
        base = 4; n0 = n_ref;
        cas_n = 1'b0; tick(ST);
        ras_n = 1'b0; tick(60);
        chk("R11 self_refresh entered", int'(self_refresh), 1);
        tick(16);
        ras_n = 1'b1; tick(ST);
        chk("R11 self_refresh left", int'(self_refresh), 0);
        cas_n = 1'b1; tick(ST);
        chk("R11 pulses in range", int'((n_ref - n0) >= 4 && (n_ref - n0) <= 6), 1);
        chk("R11 rows sequential", int'(last_ref), (base + n_ref - n0 - 1) % 8);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule